// File: doc/BRIEF.md
# Shared-Bus Request Arbitration Agent

This block is the arbitration front end of one agent on a multi-drop system bus. Up to `N_AGENTS` symmetric agents and one priority agent share the bus. Every symmetric agent runs an identical copy of this logic. The copies watch the same active-low request lines, so each one reaches the same decision about which symmetric agent owns the bus. No grant wire is needed. Each copy turns that decision, together with the priority request, the shared stall and a possible bus reset, into two things: the request level it drives onto its own pin, and an `issue_ok_o` level for its local transaction logic.

The request lines reach each agent through a rotated interconnect. Each agent therefore sees its own pin in position 0 of `breq_n_i`, and the other agents follow in ascending order after it. The logic maps that view back to absolute agent numbers. It keeps a rotating ID that names the most recent symmetric owner and passes ownership round-robin. The shared stall line is sampled only on fixed phase edges. A bus-initialisation line can return the arbitration state to its reset values, but only if that behaviour was selected while reset was held. Wired-OR lines appear as active-low inputs, already combined outside the block.

Top module: `arb_agent`

## Requirements
- R1: While `rst_n` is low and at the first edge after it, `issue_ok_o` is 0 and `req_n_o` is 1. After reset no agent owns the bus and the rotating ID equals `N_AGENTS-1`, so agent 0 comes first in line.
- R2: `req_n_o` is the inverse of `want_req_i` registered once: the value seen after edge E reflects `want_req_i` at edge E.
- R3: When nobody owns the bus, the first agent whose line is asserted is chosen. The search starts after the rotating ID and runs in ascending cyclic order. That agent becomes owner at that edge, and the rotating ID takes its number. The owner keeps the bus until its own line is sampled high. The release clears ownership at that edge, and a new grant can follow at the next edge.
- R4: Bit k of `breq_n_i` (active low) is the line of absolute agent `(AGENT_ID + k) mod N_AGENTS`. Bit 0 is this agent's own pin.
- R5: `issue_ok_o` is 1 only when all of the following are true: this agent (`AGENT_ID`) is the owner, the sampled stall is inactive, and either the registered priority request is inactive or `lock_i` is 1.
- R6: `prio_req_n_i` takes effect one edge after it is sampled. `lock_i` acts on `issue_ok_o` in the same cycle, with no delay.
- R7: The stall line `stall_n_i` (active low) is sampled only on every second edge after reset or an honoured bus-init, counting from 1: edges 2, 4, 6 and so on. Between those edges the sampled stall value holds, and `stall_n_i` has no effect.
- R8: If the configuration bit is 1 and `binit_n_i` is low at an edge, that edge resets all of the following: ownership, the rotating ID (to `N_AGENTS-1`), the registered priority request, the request drive, the stall state and the sampling phase.
- R9: If the configuration bit is 0, `binit_n_i` has no effect at all.
- R10: The configuration bit is captured from `cfg_binit_en_i` only on edges where `rst_n` is low. Changes to `cfg_binit_en_i` after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_binit_en_i | input | 1 | Bus-init observation enable, captured during reset |
| breq_n_i | input | N_AGENTS | Symmetric request lines in rotated order, active low |
| prio_req_n_i | input | 1 | Priority agent request, active low |
| stall_n_i | input | 1 | Shared block-next-request stall, active low |
| binit_n_i | input | 1 | Bus initialisation, active low |
| want_req_i | input | 1 | Local transaction logic wants the bus |
| lock_i | input | 1 | A locked sequence of this agent is in progress |
| req_n_o | output | 1 | This agent's request pin drive, active low |
| issue_ok_o | output | 1 | New transaction may be issued this cycle |

## Verification
Every registered result is due in the cycle that follows the edge at which its stimulus is sampled: the ownership change, the request drive, the priority effect and the bus-init reset. There are two exceptions. `lock_i` acts combinationally in the same cycle. A stall change appears only after the next even phase edge. The driver applies the inputs two nanoseconds after a falling edge. It then waits for the rising edge and queues the expected outputs. The monitor compares them at the next falling edge, so each comparison falls exactly one sampled edge after its stimulus. Stall pulses are placed on purpose on even and odd edges, and one bus-init comes one edge before a would-be sample point, so phase errors show up as wrong `issue_ok_o` values.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        OWN_IDLE = 1'b0,
        OWN_HELD = 1'b1
    } own_st_e;

endpackage

// File: rtl/arb_unrotate.sv
module arb_unrotate #(
    parameter int N_AGENTS = 4,
    parameter int AGENT_ID = 1
) (
    input  logic [N_AGENTS-1:0] breq_n_i,
    output logic [N_AGENTS-1:0] req_abs_o
);

    for (genvar j = 0; j < N_AGENTS; j++) begin : g_map
        localparam int K = (j + N_AGENTS - AGENT_ID) % N_AGENTS;
        assign req_abs_o[j] = ~breq_n_i[K];
    end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N_AGENTS = 4,
    localparam int ID_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [N_AGENTS-1:0] req_i,
    input  logic [ID_W-1:0]     last_i,
    output logic                any_o,
    output logic [ID_W-1:0]     next_o
);

    always_comb begin
        int idx;
        any_o  = 1'b0;
        next_o = '0;
        idx    = 0;
        // scan farthest first so the nearest requester after last_i wins
        for (int k = N_AGENTS; k >= 1; k--) begin
            idx = (int'(last_i) + k) % N_AGENTS;
            if (req_i[idx]) begin
                any_o  = 1'b1;
                next_o = ID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/arb_stall_phase.sv
module arb_stall_phase #(
    parameter int PERIOD = 2,
    localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic stall_n_i,
    output logic stall_o
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            stall;
    } ph_st_t;

    localparam ph_st_t PH_RESET = '{phase: '0, stall: 1'b0};

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_W'(PERIOD - 1)) begin
            st_d.phase = '0;
            st_d.stall = ~stall_n_i;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
        if (restart_i) begin
            st_d = PH_RESET;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PH_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_o = st_q.stall;

endmodule

// File: rtl/arb_agent.sv
module arb_agent
    import arb_pkg::*;
#(
    parameter int N_AGENTS     = 4,
    parameter int AGENT_ID     = 1,
    parameter int STALL_PERIOD = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_binit_en_i,
    input  logic [N_AGENTS-1:0] breq_n_i,
    input  logic                prio_req_n_i,
    input  logic                stall_n_i,
    input  logic                binit_n_i,
    input  logic                want_req_i,
    input  logic                lock_i,
    output logic                req_n_o,
    output logic                issue_ok_o
);

    localparam int ID_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;
    localparam logic [ID_W-1:0] SELF_ID = ID_W'(AGENT_ID);

    typedef struct packed {
        own_st_e         own;
        logic [ID_W-1:0] rid;
        logic            prio;
        logic            req;
    } agt_st_t;

    localparam agt_st_t AGT_RESET = '{
        own:  OWN_IDLE,
        rid:  ID_W'(N_AGENTS - 1),
        prio: 1'b0,
        req:  1'b0
    };

    agt_st_t st_d, st_q;
    logic    cfg_q;
    logic    binit_hit;
    logic    stall;
    logic    pick_any;
    logic [ID_W-1:0]     pick_next;
    logic [N_AGENTS-1:0] req_abs;

    assign binit_hit = cfg_q & ~binit_n_i;

    arb_unrotate #(
        .N_AGENTS (N_AGENTS),
        .AGENT_ID (AGENT_ID)
    ) i_unrotate (
        .breq_n_i  (breq_n_i),
        .req_abs_o (req_abs)
    );

    arb_rr_pick #(
        .N_AGENTS (N_AGENTS)
    ) i_pick (
        .req_i  (req_abs),
        .last_i (st_q.rid),
        .any_o  (pick_any),
        .next_o (pick_next)
    );

    arb_stall_phase #(
        .PERIOD (STALL_PERIOD)
    ) i_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (binit_hit),
        .stall_n_i (stall_n_i),
        .stall_o   (stall)
    );

    always_comb begin
        st_d      = st_q;
        st_d.req  = want_req_i;
        st_d.prio = ~prio_req_n_i;
        if (st_q.own == OWN_HELD) begin
            if (!req_abs[st_q.rid]) begin
                st_d.own = OWN_IDLE;
            end
        end else if (pick_any) begin
            st_d.own = OWN_HELD;
            st_d.rid = pick_next;
        end
        if (binit_hit) begin
            st_d = AGT_RESET;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= AGT_RESET;
            cfg_q <= cfg_binit_en_i;
        end else begin
            st_q  <= st_d;
        end
    end

    assign req_n_o    = ~st_q.req;
    assign issue_ok_o = (st_q.own == OWN_HELD) && (st_q.rid == SELF_ID) &&
                        !stall && (!st_q.prio || lock_i);

endmodule

// File: rtl/arb_agent_chk.sv
module arb_agent_chk #(
    parameter int N_AGENTS = 4,
    localparam int ID_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            want_req_i,
    input logic            prio_req_n_i,
    input logic            own_line_n,
    input logic            lock_i,
    input logic            req_n_o,
    input logic            issue_ok_o,
    input logic            cfg_q,
    input logic            binit_hit,
    input logic            busy,
    input logic [ID_W-1:0] rid
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R2
    req_drive_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$past(binit_hit) |-> req_n_o == !$past(want_req_i));

    // R5
    own_line_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        issue_ok_o |-> !$past(own_line_n));

    // R3
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(busy) && busy) |-> rid == $past(rid));

    // R6
    prio_block_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (issue_ok_o && !lock_i) |-> ($past(prio_req_n_i) || $past(binit_hit)));

    // R8
    binit_reset_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(binit_hit) |-> (!busy && rid == ID_W'(N_AGENTS - 1) && req_n_o));

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $stable(cfg_q));

endmodule

bind arb_agent arb_agent_chk #(.N_AGENTS(N_AGENTS)) i_arb_agent_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .want_req_i   (want_req_i),
    .prio_req_n_i (prio_req_n_i),
    .own_line_n   (breq_n_i[0]),
    .lock_i       (lock_i),
    .req_n_o      (req_n_o),
    .issue_ok_o   (issue_ok_o),
    .cfg_q        (cfg_q),
    .binit_hit    (binit_hit),
    .busy         (st_q.own == arb_pkg::OWN_HELD),
    .rid          (st_q.rid)
);

// File: tb/test_arb_agent.sv
module test_arb_agent;

    localparam int N   = 4;
    localparam int AID = 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_binit_en_i;
    logic [N-1:0] breq_n_i;
    logic         prio_req_n_i;
    logic         stall_n_i;
    logic         binit_n_i;
    logic         want_req_i;
    logic         lock_i;
    logic         req_n_o;
    logic         issue_ok_o;

    typedef struct {
        string tag;
        bit    ok;
        bit    rn;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    arb_agent #(.N_AGENTS(N), .AGENT_ID(AID), .STALL_PERIOD(2)) i_arb_agent (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_binit_en_i (cfg_binit_en_i),
        .breq_n_i       (breq_n_i),
        .prio_req_n_i   (prio_req_n_i),
        .stall_n_i      (stall_n_i),
        .binit_n_i      (binit_n_i),
        .want_req_i     (want_req_i),
        .lock_i         (lock_i),
        .req_n_o        (req_n_o),
        .issue_ok_o     (issue_ok_o)
    );

    // absolute request vector (bit = agent number, 1 = requesting) to rotated pins (R4)
    function automatic logic [N-1:0] rotate(input logic [N-1:0] a);
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) r[k] = ~a[(AID + k) % N];
        return r;
    endfunction

    task automatic step(input logic [N-1:0] a, input bit want, input bit stn,
                        input bit prn, input bit lk, input bit bin,
                        input bit e_ok, input bit e_rn, input string tag);
        exp_t e;
        breq_n_i     = rotate(a);
        want_req_i   = want;
        stall_n_i    = stn;
        prio_req_n_i = prn;
        lock_i       = lk;
        binit_n_i    = bin;
        @(posedge clk);
        #1;
        e.tag = tag; e.ok = e_ok; e.rn = e_rn;
        exp_q.push_back(e);
        @(negedge clk);
        #2;
    endtask

    task automatic check_now(input string tag, input bit e_ok, input bit e_rn);
        n_chk++;
        if (issue_ok_o !== e_ok || req_n_o !== e_rn) begin
            n_fail++;
            $display("FAIL %s: issue_ok=%b req_n=%b expected issue_ok=%b req_n=%b",
                     tag, issue_ok_o, req_n_o, e_ok, e_rn);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check_now(e.tag, e.ok, e.rn);
            end
        end
    end

    initial begin : watchdog
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0; cfg_binit_en_i = 1'b1;
        breq_n_i = '1; want_req_i = 1'b0; stall_n_i = 1'b1;
        prio_req_n_i = 1'b1; lock_i = 1'b0; binit_n_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("R1 reset state", 1'b0, 1'b1);
        #2;
        rst_n = 1'b1;
        //    a        want stn prn lk bin  ok rn
        step(4'b0010, 1, 1, 1, 0, 1, 1, 0, "R3 R4 R2 first grant to self after reset");
        step(4'b0010, 1, 0, 1, 0, 1, 0, 0, "R7 stall sampled on edge 2");
        step(4'b0010, 1, 1, 1, 0, 1, 0, 0, "R7 stall held on odd edge");
        step(4'b0010, 1, 1, 1, 0, 1, 1, 0, "R7 stall cleared on edge 4");
        step(4'b0010, 1, 0, 1, 0, 1, 1, 0, "R7 stall ignored on odd edge");
        step(4'b0010, 1, 1, 1, 0, 1, 1, 0, "R7 next sample sees no stall");
        step(4'b0010, 1, 1, 0, 0, 1, 0, 0, "R6 R5 priority request blocks issue");
        step(4'b0010, 1, 1, 0, 1, 1, 1, 0, "R6 locked sequence exempt");
        step(4'b0010, 1, 1, 1, 0, 1, 1, 0, "R6 priority released");
        step(4'b1000, 0, 1, 1, 0, 1, 0, 1, "R3 R2 owner releases");
        step(4'b1000, 0, 1, 1, 0, 1, 0, 1, "R3 agent 3 granted");
        step(4'b1010, 1, 1, 1, 0, 1, 0, 0, "R3 owner keeps bus");
        step(4'b0010, 1, 1, 1, 0, 1, 0, 0, "R3 agent 3 releases");
        step(4'b0011, 1, 1, 1, 0, 1, 0, 0, "R3 agent 0 follows 3 in rotation");
        step(4'b0010, 1, 1, 1, 0, 1, 0, 0, "R3 agent 0 releases");
        step(4'b0010, 1, 1, 1, 0, 1, 1, 0, "R3 self granted after 0");
        step(4'b0010, 1, 1, 1, 0, 0, 0, 1, "R8 bus-init resets state");
        step(4'b0110, 1, 0, 1, 0, 1, 1, 0, "R8 rotating id and phase restarted");
        step(4'b0110, 1, 0, 1, 0, 1, 0, 0, "R8 R7 sample on new phase");
        step(4'b0110, 1, 1, 1, 0, 1, 0, 0, "R7 held after bus-init");
        step(4'b0110, 1, 1, 1, 0, 1, 1, 0, "R7 cleared on new phase");
        // second reset with bus-init observation disabled
        rst_n = 1'b0; cfg_binit_en_i = 1'b0;
        breq_n_i = '1; want_req_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_now("R1 reset state again", 1'b0, 1'b1);
        #2;
        rst_n = 1'b1;
        step(4'b0010, 1, 1, 1, 0, 1, 1, 0, "R3 grant after second reset");
        step(4'b0010, 1, 1, 1, 0, 0, 1, 0, "R9 bus-init ignored when disabled");
        cfg_binit_en_i = 1'b1;
        step(4'b0010, 1, 1, 1, 0, 1, 1, 0, "R10 config change after reset");
        step(4'b0010, 1, 1, 1, 0, 0, 1, 0, "R10 R9 bus-init still ignored");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule